// File: doc/BRIEF.md
# Latency-Aware Micro-Operation Sequencer

The sequencer sits between an instruction translator and the decode register of a transport-triggered core that runs operation-triggered code. Each translated instruction comes in as a bundle: the moves that deliver input operands, one move that carries the result back to the register file, an operation index, a control-flow class and an immediate. The input moves leave in the cycle the bundle is accepted. The result move is parked in a register and released only once the operation's latency has elapsed. That latency is read from a per-operation table, and the sequencer issues empty moves (bubbles) in the cycles between.

Control flow is sorted into classes. Jumps with an immediate target, and PC-relative upper-immediate adds, hand their immediate straight to the control unit, and their result move is still scheduled like any other. Conditional branches and register-indirect jumps stall instruction fetch, go out as a normal micro-operation, and force one bubble cycle while the control unit resolves them. An external controller can also force a bubble at any time. This blanks the output and freezes the sequencer's state.

Top module: `useq_sequencer`

## Requirements
- R1: After a synchronous active-high reset, with no input valid, `in_ready` is 1, and `out_in_moves`, `out_res_move`, `fetch_stall`, `cu_req` and `cu_imm` are all 0.
- R2: When a bundle is accepted (`in_valid` and `in_ready` both high), its input moves appear on `out_in_moves` in the same cycle. In any cycle without an accept, `out_in_moves` is 0 (a no-op).
- R3: For an operation of latency 1, the result move appears on `out_res_move` exactly one cycle after the accept. `out_res_move` is 0 in every cycle in which no result is released.
- R4: For an operation of latency L (1 to 8), the result move appears exactly L cycles after the accept. `in_ready` is 0 for the L-1 cycles between, and those cycles carry no-op moves.
- R5: In the cycle that releases a held result move, `in_ready` is 1. A new bundle accepted in that cycle has its input moves issued in the same cycle as the old result move.
- R6: The latency of operation i is one plus the 3-bit field at bits [3i+2:3i] of parameter `LAT_TABLE`. The default table gives latencies 1,1,2,3,8,1,4,5 for operations 0 to 7.
- R7: While `ctl_bubble` is 1, all move outputs, `cu_req` and `in_ready` are 0, and no state advances. A pending result is released that many cycles later than it otherwise would be.
- R8: Class 01 (direct jump or PC-relative add) asserts `cu_req`, with `cu_imm` equal to `in_imm`, in the accept cycle only. Its result move is released after its table latency.
- R9: Class 10 (branch or register-indirect jump) raises `fetch_stall` in the accept cycle and in the cycle after it. In that following cycle, `in_ready` is 0.
- R10: A bundle presented while `in_ready` is 0 is ignored. It issues no moves and raises no `cu_req`, and the held result move keeps its earlier value.
- R11: Classes 00 and 11 are plain operations. They raise neither `cu_req` nor `fetch_stall`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Translated bundle present |
| in_op | input | OP_W (3) | Operation index into the latency table |
| in_kind | input | 2 | Class: 00 plain, 01 direct to control unit, 10 resolve with stall, 11 plain |
| in_in_moves | input | IN_W (16) | Input operand moves |
| in_res_move | input | RES_W (8) | Result move to the register file |
| in_imm | input | IMM_W (32) | Sign-extended immediate |
| ctl_bubble | input | 1 | Controller bubble: blank output and freeze |
| in_ready | output | 1 | A bundle may be accepted this cycle |
| out_in_moves | output | IN_W (16) | Input moves to the decode register |
| out_res_move | output | RES_W (8) | Result move to the decode register |
| fetch_stall | output | 1 | Hold instruction fetch |
| cu_req | output | 1 | Immediate handed to the control unit |
| cu_imm | output | IMM_W (32) | Immediate for the control unit |

## Verification
A corrupted latency counter shows up at the ports as a result move that leaves one or more cycles early or late. It also shows as `in_ready` returning high in the wrong cycle, and both are visible within the latency window of a single instruction. A wrong held result register shows up in the release cycle as the wrong move value, for example one taken from a bundle that should have been ignored. A stuck branch-bubble flag keeps `fetch_stall` high, or lets `in_ready` rise, in the cycle right after a class-10 accept.

// File: rtl/useq_pkg.sv
package useq_pkg;
  typedef enum logic [1:0] {
    FK_PLAIN   = 2'b00,
    FK_DIRECT  = 2'b01,
    FK_RESOLVE = 2'b10,
    FK_PLAIN2  = 2'b11
  } flow_kind_e;

  function automatic logic is_direct(input logic [1:0] k);
    return flow_kind_e'(k) == FK_DIRECT;
  endfunction

  function automatic logic is_resolve(input logic [1:0] k);
    return flow_kind_e'(k) == FK_RESOLVE;
  endfunction
endpackage

// File: rtl/useq_lat_lut.sv
module useq_lat_lut #(
  parameter int NUM_OPS = 8,
  parameter int OP_W = 3,
  parameter int LAT_W = 3,
  parameter int CNT_W = 4,
  parameter logic [NUM_OPS*LAT_W-1:0] LAT_TABLE = '0
) (
  input  logic [OP_W-1:0]  op,
  output logic [CNT_W-1:0] lat
);
  logic [LAT_W-1:0] field_arr [NUM_OPS];

  genvar gi;
  generate
    for (gi = 0; gi < NUM_OPS; gi++) begin : g_field
      assign field_arr[gi] = LAT_TABLE[gi*LAT_W +: LAT_W];
    end
  endgenerate

  function automatic logic [CNT_W-1:0] field_to_lat(input logic [LAT_W-1:0] f);
    return CNT_W'(f) + CNT_W'(1);
  endfunction

  always_comb begin
    if (int'(op) < NUM_OPS) lat = field_to_lat(field_arr[op]);
    else                    lat = CNT_W'(1);
  end
endmodule

// File: rtl/useq_result_hold.sv
module useq_result_hold #(
  parameter int RES_W = 8,
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             freeze,
  input  logic             load,
  input  logic [CNT_W-1:0] load_lat,
  input  logic [RES_W-1:0] load_res,
  output logic             res_fire,
  output logic             busy_long,
  output logic [RES_W-1:0] res_out
);
  logic [CNT_W-1:0] cnt_q;
  logic [RES_W-1:0] held_q;

  assign res_fire  = !freeze && (cnt_q == CNT_W'(1));
  assign busy_long = cnt_q > CNT_W'(1);
  assign res_out   = res_fire ? held_q : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      held_q <= '0;
    end else if (!freeze) begin
      if (load) begin
        cnt_q  <= load_lat;
        held_q <= load_res;
      end else if (cnt_q != '0) begin
        cnt_q <= cnt_q - CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/useq_flow_ctl.sv
module useq_flow_ctl #(
  parameter int IMM_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             freeze,
  input  logic             acc,
  input  logic [1:0]       kind,
  input  logic [IMM_W-1:0] imm,
  output logic             br_bub,
  output logic             fetch_stall,
  output logic             cu_req,
  output logic [IMM_W-1:0] cu_imm
);
  import useq_pkg::*;

  logic acc_resolve;

  assign acc_resolve = acc && is_resolve(kind);
  assign fetch_stall = acc_resolve || br_bub;
  assign cu_req      = acc && is_direct(kind);
  assign cu_imm      = cu_req ? imm : '0;

  always_ff @(posedge clk) begin
    if (rst)          br_bub <= 1'b0;
    else if (!freeze) br_bub <= acc_resolve;
  end
endmodule

// File: rtl/useq_sequencer.sv
module useq_sequencer #(
  parameter int NUM_OPS = 8,
  parameter int LAT_W = 3,
  parameter int IN_W = 16,
  parameter int RES_W = 8,
  parameter int IMM_W = 32,
  parameter logic [NUM_OPS*LAT_W-1:0] LAT_TABLE = 24'h8C7440,
  localparam int OP_W = (NUM_OPS > 1) ? $clog2(NUM_OPS) : 1,
  localparam int CNT_W = $clog2((1 << LAT_W) + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [OP_W-1:0]  in_op,
  input  logic [1:0]       in_kind,
  input  logic [IN_W-1:0]  in_in_moves,
  input  logic [RES_W-1:0] in_res_move,
  input  logic [IMM_W-1:0] in_imm,
  input  logic             ctl_bubble,
  output logic             in_ready,
  output logic [IN_W-1:0]  out_in_moves,
  output logic [RES_W-1:0] out_res_move,
  output logic             fetch_stall,
  output logic             cu_req,
  output logic [IMM_W-1:0] cu_imm
);
  logic             acc;
  logic [CNT_W-1:0] acc_lat;
  logic             res_fire;
  logic             busy_long;
  logic             br_bub;

  assign in_ready     = !ctl_bubble && !br_bub && !busy_long;
  assign acc          = in_valid && in_ready;
  assign out_in_moves = acc ? in_in_moves : '0;

  useq_lat_lut #(
    .NUM_OPS(NUM_OPS), .OP_W(OP_W), .LAT_W(LAT_W), .CNT_W(CNT_W),
    .LAT_TABLE(LAT_TABLE)
  ) u_lut (
    .op (in_op),
    .lat(acc_lat)
  );

  useq_result_hold #(.RES_W(RES_W), .CNT_W(CNT_W)) u_hold (
    .clk      (clk),
    .rst      (rst),
    .freeze   (ctl_bubble),
    .load     (acc),
    .load_lat (acc_lat),
    .load_res (in_res_move),
    .res_fire (res_fire),
    .busy_long(busy_long),
    .res_out  (out_res_move)
  );

  useq_flow_ctl #(.IMM_W(IMM_W)) u_flow (
    .clk        (clk),
    .rst        (rst),
    .freeze     (ctl_bubble),
    .acc        (acc),
    .kind       (in_kind),
    .imm        (in_imm),
    .br_bub     (br_bub),
    .fetch_stall(fetch_stall),
    .cu_req     (cu_req),
    .cu_imm     (cu_imm)
  );
endmodule

// File: rtl/useq_checker.sv
module useq_checker #(
  parameter int IN_W = 16,
  parameter int RES_W = 8,
  parameter int IMM_W = 32,
  parameter int CNT_W = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic [1:0]       in_kind,
  input logic [RES_W-1:0] in_res_move,
  input logic [IMM_W-1:0] in_imm,
  input logic             ctl_bubble,
  input logic             in_ready,
  input logic [IN_W-1:0]  out_in_moves,
  input logic [RES_W-1:0] out_res_move,
  input logic             fetch_stall,
  input logic             cu_req,
  input logic [IMM_W-1:0] cu_imm,
  input logic             acc,
  input logic [CNT_W-1:0] acc_lat,
  input logic             busy_long
);
  // R4
  ready_low_when_busy_chk: assert property (@(posedge clk) disable iff (rst)
    busy_long |-> !in_ready);

  // R3
  lat1_release_chk: assert property (@(posedge clk) disable iff (rst)
    (acc && acc_lat == CNT_W'(1)) |=> (ctl_bubble || out_res_move == $past(in_res_move)));

  // R7
  bubble_blank_chk: assert property (@(posedge clk) disable iff (rst)
    ctl_bubble |-> (out_in_moves == '0 && out_res_move == '0 && !in_ready && !cu_req));

  // R9
  resolve_stall_chk: assert property (@(posedge clk) disable iff (rst)
    (acc && in_kind == 2'b10) |=> (fetch_stall && !in_ready));

  // R8
  direct_req_chk: assert property (@(posedge clk) disable iff (rst)
    cu_req |-> (in_valid && in_kind == 2'b01 && cu_imm == in_imm));

  // R10
  ignored_input_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !in_ready) |-> (out_in_moves == '0 && !cu_req));
endmodule

bind useq_sequencer useq_checker #(
  .IN_W(IN_W), .RES_W(RES_W), .IMM_W(IMM_W), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_kind(in_kind),
  .in_res_move(in_res_move), .in_imm(in_imm), .ctl_bubble(ctl_bubble),
  .in_ready(in_ready), .out_in_moves(out_in_moves), .out_res_move(out_res_move),
  .fetch_stall(fetch_stall), .cu_req(cu_req), .cu_imm(cu_imm),
  .acc(acc), .acc_lat(acc_lat), .busy_long(busy_long)
);

// File: tb/tb_useq_sequencer.sv
`timescale 1ns/1ps
module tb_useq_sequencer;
  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic [2:0]  in_op;
  logic [1:0]  in_kind;
  logic [15:0] in_in_moves;
  logic [7:0]  in_res_move;
  logic [31:0] in_imm;
  logic        ctl_bubble;
  logic        in_ready;
  logic [15:0] out_in_moves;
  logic [7:0]  out_res_move;
  logic        fetch_stall;
  logic        cu_req;
  logic [31:0] cu_imm;

  int errs = 0;
  int checks = 0;

  always #5 clk = ~clk;

  useq_sequencer dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_op(in_op), .in_kind(in_kind),
    .in_in_moves(in_in_moves), .in_res_move(in_res_move), .in_imm(in_imm),
    .ctl_bubble(ctl_bubble), .in_ready(in_ready), .out_in_moves(out_in_moves),
    .out_res_move(out_res_move), .fetch_stall(fetch_stall), .cu_req(cu_req),
    .cu_imm(cu_imm)
  );

  function automatic int want_lat(input int op);
    case (op)
      2: return 2;
      3: return 3;
      4: return 8;
      6: return 4;
      7: return 5;
      default: return 1;
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input logic v, input logic [2:0] op, input logic [1:0] k,
                      input logic [15:0] mv, input logic [7:0] rm,
                      input logic [31:0] im, input logic bub);
    @(negedge clk);
    in_valid = v; in_op = op; in_kind = k; in_in_moves = mv;
    in_res_move = rm; in_imm = im; ctl_bubble = bub;
    #2;
  endtask

  task automatic idle();
    step(1'b0, 3'd0, 2'd0, 16'h0, 8'h0, 32'h0, 1'b0);
  endtask

  task automatic t_reset();
    idle();
    chk("R1 ready", in_ready, 1);
    chk("R1 in_moves", out_in_moves, 0);
    chk("R1 res_move", out_res_move, 0);
    chk("R1 fetch_stall", fetch_stall, 0);
    chk("R1 cu_req", cu_req, 0);
    chk("R1 cu_imm", cu_imm, 0);
  endtask

  task automatic t_lat1();
    step(1'b1, 3'd0, 2'd0, 16'hA1B2, 8'h3C, 32'h0, 1'b0);
    chk("R2 in moves same cycle", out_in_moves, 16'hA1B2);
    chk("R3 no result yet", out_res_move, 0);
    chk("R11 plain no cu_req", cu_req, 0);
    chk("R11 plain no stall", fetch_stall, 0);
    idle();
    chk("R3 result one cycle later", out_res_move, 8'h3C);
    chk("R2 idle no-op moves", out_in_moves, 0);
    idle();
    chk("R3 result gone", out_res_move, 0);
    step(1'b1, 3'd5, 2'd3, 16'h0F0F, 8'h4D, 32'hFFFF0000, 1'b0);
    chk("R11 class 11 no cu_req", cu_req, 0);
    chk("R11 class 11 no stall", fetch_stall, 0);
    idle();
    chk("R3 class 11 result", out_res_move, 8'h4D);
    idle();
  endtask

  task automatic t_long();
    step(1'b1, 3'd4, 2'd0, 16'h1234, 8'h9A, 32'h0, 1'b0);
    chk("R2 long op in moves", out_in_moves, 16'h1234);
    for (int k = 1; k < 8; k++) begin
      step(1'b1, 3'd1, 2'd1, 16'h4321, 8'h11, 32'hDEAD, 1'b0);
      chk("R4 ready low in window", in_ready, 0);
      chk("R10 ignored no moves", out_in_moves, 0);
      chk("R10 ignored no cu_req", cu_req, 0);
      chk("R4 no early result", out_res_move, 0);
    end
    step(1'b1, 3'd1, 2'd0, 16'h5678, 8'h22, 32'h0, 1'b0);
    chk("R5 ready in release cycle", in_ready, 1);
    chk("R4 R10 held result after 8", out_res_move, 8'h9A);
    chk("R5 shared cycle in moves", out_in_moves, 16'h5678);
    idle();
    chk("R5 following result", out_res_move, 8'h22);
    idle();
  endtask

  task automatic t_table();
    for (int op = 0; op < 8; op++) begin
      int n;
      step(1'b1, 3'(op), 2'd0, 16'h0001, 8'hE0 | 8'(op), 32'h0, 1'b0);
      n = 0;
      for (int g = 0; g < 12; g++) begin
        idle();
        n++;
        if (out_res_move != 0) break;
      end
      chk($sformatf("R6 latency op%0d", op), 32'(n), 32'(want_lat(op)));
      chk($sformatf("R6 value op%0d", op), out_res_move, 8'hE0 | 8'(op));
    end
    idle();
  endtask

  task automatic t_bubble();
    step(1'b1, 3'd3, 2'd0, 16'h0A0A, 8'h55, 32'h0, 1'b0);
    for (int k = 0; k < 2; k++) begin
      step(1'b1, 3'd0, 2'd1, 16'hBEEF, 8'h66, 32'h77, 1'b1);
      chk("R7 bubble in moves", out_in_moves, 0);
      chk("R7 bubble res move", out_res_move, 0);
      chk("R7 bubble ready", in_ready, 0);
      chk("R7 bubble cu_req", cu_req, 0);
    end
    idle(); chk("R7 frozen count a", out_res_move, 0);
    idle(); chk("R7 frozen count b", out_res_move, 0);
    idle(); chk("R7 delayed release", out_res_move, 8'h55);
    idle();
  endtask

  task automatic t_direct();
    step(1'b1, 3'd2, 2'd1, 16'h0C0C, 8'h3D, 32'h12345678, 1'b0);
    chk("R8 cu_req", cu_req, 1);
    chk("R8 cu_imm", cu_imm, 32'h12345678);
    chk("R8 no stall", fetch_stall, 0);
    idle();
    chk("R8 cu_req one cycle", cu_req, 0);
    chk("R8 cu_imm cleared", cu_imm, 0);
    chk("R4 ready low lat2", in_ready, 0);
    chk("R8 result not yet", out_res_move, 0);
    idle();
    chk("R8 result scheduled", out_res_move, 8'h3D);
    idle();
  endtask

  task automatic t_resolve();
    step(1'b1, 3'd0, 2'd2, 16'h0BB0, 8'h77, 32'h40, 1'b0);
    chk("R9 stall accept cycle", fetch_stall, 1);
    chk("R9 moves issued", out_in_moves, 16'h0BB0);
    chk("R9 no cu_req", cu_req, 0);
    step(1'b1, 3'd0, 2'd0, 16'h0CC0, 8'h88, 32'h0, 1'b0);
    chk("R9 stall bubble cycle", fetch_stall, 1);
    chk("R9 ready low bubble", in_ready, 0);
    chk("R9 bubble no moves", out_in_moves, 0);
    chk("R3 resolve result", out_res_move, 8'h77);
    idle();
    chk("R9 stall released", fetch_stall, 0);
    chk("R9 ready back", in_ready, 1);
    chk("R10 ignored res absent", out_res_move, 0);
    idle();
  endtask

  initial begin
    #2_000_000;
    errs++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errs, checks + 1);
    $finish;
  end

  initial begin
    rst = 1'b1; in_valid = 0; in_op = 0; in_kind = 0; in_in_moves = 0;
    in_res_move = 0; in_imm = 0; ctl_bubble = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_lat1();
    t_long();
    t_table();
    t_bubble();
    t_direct();
    t_resolve();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule